// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a countdown watchdog that software drives only through 16-bit key writes and a handful of configuration words on a simple synchronous bus. The bus has a byte address, a write strobe, write data and combinational read data. One key opens the configuration words for writing. A second key starts the timer, and a third key refreshes it. Writing any other key value closes the configuration words again. Once the timer is started, software cannot stop it; only the block reset returns it to idle.

A selectable prescaler divides the clock and paces a 12-bit down-counter, which is loaded from a reload word. When the counter runs out, the block raises a one-cycle reset request and reloads. A refresh that comes while the counter is still above a programmable window value also raises a reset request, provided the window is set narrower than the reload value. An early warning flag, with its own enable, is set when the counter falls to a programmable threshold. Software clears it by writing one to an acknowledge bit. Each configuration word passes through a pending stage, and a busy flag in the status word shows while a new value is being applied.

Word map (index = address bits 4:2): 0 key, 1 prescaler code, 2 reload, 3 status, 4 window, 5 early-warning control.

Top module: `kwdt_top`

## Requirements
- R1: After reset the key word reads 0, the prescaler code reads 0, reload and window read 0xFFF, the status word and the early-warning word read 0, and both outputs are low.
- R2: Writing 0x5555 to the key word (data bits 15:0) opens the prescaler, reload and window words for writing. A key write of any other value closes them. While they are closed, writes to these words leave them unchanged.
- R3: An accepted write to the prescaler, reload or window word sets status bit 0, 1 or 2 respectively for exactly 3 cycles. A further write to the same word while its bit is set is dropped. The new value takes effect as that bit clears.
- R4: The prescaler code (bits 3:0) divides the clock by 4 << code for codes 0 to 8; codes above 8 divide by 1024.
- R5: A 0xCCCC key write while idle loads the counter from the reload value R and starts it. With division D, the reset request output pulses high for one cycle (R+1)*D cycles after the start write, and the counter reloads and repeats.
- R6: A 0xAAAA key write while running reloads the counter and restarts the prescaler. While idle it has no effect.
- R7: If a refresh arrives while the counter is above the window value and the window value is below the reload value, the reset request pulses in the next cycle and the counter is not reloaded.
- R8: With the enable (early-warning word bit 15) set, the early flag (status bit 14, also the early_irq output) sets one cycle after the counter first satisfies counter <= threshold - 1 (threshold in bits 11:0). With the enable clear, it never sets.
- R9: Writing the early-warning word with bit 14 set clears the early flag. Writing it with bit 14 clear leaves the flag set. Bit 14 reads as 0.
- R10: A write to the early-warning word sets status bit 3 for 3 cycles. Threshold and enable writes made while bit 3 is set are dropped.
- R11: Once started, no key write stops the timer; only the block reset returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdg_reset_req | output | 1 | One-cycle reset request on expiry or window violation |
| early_irq | output | 1 | Early-warning flag |

## Verification
The countdown is run with several prescaler codes and reload values, including the slowest code, a code above the legal range and a zero reload. The expiry is measured to the exact cycle, which separates an off-by-one in the divider from one in the counter. Refreshes are issued at three points: before the start, inside the window, and above the window. A refresh that was wrongly ignored, wrongly accepted or that reloaded the counter each moves the measured expiry or the pulse by a known number of cycles. Back-to-back writes during a busy period, key writes other than the unlock key, and early-warning writes with and without the acknowledge bit are each followed by readback or output checks, to show which write was dropped and which flag survived.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    typedef enum logic [2:0] {
        IDX_KEY  = 3'd0,
        IDX_PRE  = 3'd1,
        IDX_RLD  = 3'd2,
        IDX_STAT = 3'd3,
        IDX_WIN  = 3'd4,
        IDX_EWC  = 3'd5
    } reg_idx_e;

    localparam logic [15:0] KEY_OPEN    = 16'h5555;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_START   = 16'hCCCC;

    localparam int EW_ACK_BIT  = 14;
    localparam int EW_EN_BIT   = 15;
    localparam int ST_FLAG_BIT = 14;

    // Last count value of the prescaler for a given code: (4 << code) - 1.
    function automatic logic [31:0] div_last(input logic [3:0] code, input int max_code);
        int eff;
        eff = (int'(code) > max_code) ? max_code : int'(code);
        return (32'd4 << eff) - 32'd1;
    endfunction

endpackage

// File: rtl/kwdt_shadow.sv
module kwdt_shadow #(
    parameter int             W        = 12,
    parameter logic [W-1:0]   RST_VAL  = '0,
    parameter int             BUSY_CYC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] act_o,
    output logic         busy_o
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [BW-1:0] cnt;
        logic [W-1:0]  pend;
        logic [W-1:0]  act;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d = q;
        if (wr_i && q.cnt == '0) begin
            d.pend = data_i;
            d.cnt  = BW'(BUSY_CYC);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - BW'(1);
            if (q.cnt == BW'(1)) d.act = q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.pend <= RST_VAL;
            q.act  <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign pend_o = q.pend;
    assign act_o  = q.act;
    assign busy_o = (q.cnt != '0);

    // R3 / R10: a write during the busy period leaves the pending value alone
    a_r3_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && busy_o) |=> (pend_o == $past(pend_o)));

    // R3: the applied value only moves at the end of the busy period
    a_r3_apply_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o != d.act) |-> (q.cnt == BW'(1)));

endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8,
    parameter int DIV_W    = 2 + MAX_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    import kwdt_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } ps_t;

    ps_t q, d;
    logic [DIV_W-1:0] last;
    logic [31:0]      last_full;
    logic [31:0]      last_unused;

    always_comb begin
        last_full   = div_last(4'(code_i), MAX_CODE);
        last        = last_full[DIV_W-1:0];
        last_unused = last_full;
        tick_o      = run_i && (q.div == last);
        d           = q;
        if (clr_i || !run_i || tick_o) d.div = '0;
        else                           d.div = q.div + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: the smallest division is 4, so ticks never come on adjacent cycles
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core #(
    parameter int               CNT_W   = 12,
    parameter logic [CNT_W-1:0] CNT_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             refresh_i,
    input  logic             tick_i,
    input  logic             ack_i,
    input  logic             ew_en_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] win_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             running_o,
    output logic             load_o,
    output logic             rst_req_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             running;
        logic             rst_req;
        logic             near;
        logic             flag;
    } core_t;

    core_t q, d;
    logic start_go, viol, refresh_go, expire, near, set_flag;

    always_comb begin
        d          = q;
        start_go   = start_i && !q.running;
        viol       = refresh_i && q.running && (q.cnt > win_i) && (win_i < reload_i);
        refresh_go = refresh_i && q.running && !viol;
        expire     = tick_i && q.running && (q.cnt == '0);
        if (start_go) d.running = 1'b1;
        if (start_go || refresh_go)     d.cnt = reload_i;
        else if (tick_i && q.running)   d.cnt = expire ? reload_i : q.cnt - CNT_W'(1);
        d.rst_req  = viol || expire;
        near       = q.running && ew_en_i &&
                     (({1'b0, q.cnt} + (CNT_W+1)'(1)) <= {1'b0, thr_i});
        d.near     = near;
        set_flag   = near && !q.near;
        d.flag     = set_flag || (q.flag && !ack_i);
        load_o     = start_go || refresh_go;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt     <= CNT_RST;
            q.running <= 1'b0;
            q.rst_req <= 1'b0;
            q.near    <= 1'b0;
            q.flag    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign running_o = q.running;
    assign rst_req_o = q.rst_req;
    assign flag_o    = q.flag;

    // R11: nothing but the block reset clears the running state
    a_r11_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |=> running_o);

    // R5: expiry reloads the counter and requests a reset
    a_r5_expiry_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && running_o && q.cnt == '0) |=> (rst_req_o && q.cnt == $past(reload_i)));

    // R7: a refresh above the window holds the counter and requests a reset
    a_r7_hold_on_violation: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i && running_o && !tick_i && q.cnt > win_i && win_i < reload_i)
        |=> (rst_req_o && $stable(q.cnt)));

    // R8: the flag can only rise while the enable is set
    a_r8_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(ew_en_i));

    // R9: an acknowledge with no new crossing clears the flag
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && q.near) |=> !flag_o);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 12,
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8,
    parameter int BUSY_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdg_reset_req,
    output logic              early_irq
);
    import kwdt_pkg::*;

    localparam int EW_W = CNT_W + 1;

    typedef struct packed {
        logic open;
    } top_t;

    top_t q, d;

    logic [2:0]  idx;
    logic        key_wr, start_k, refresh_k, ack;
    logic        pre_wr, rld_wr, win_wr, ew_wr;
    logic [CODE_W-1:0] pre_pend, pre_act;
    logic [CNT_W-1:0]  rld_pend, rld_act, win_pend, win_act;
    logic [EW_W-1:0]   ew_pend, ew_act;
    logic        pre_busy, rld_busy, win_busy, ew_busy;
    logic        tick, running, load;
    logic [15:0] key;
    logic        addr_unused;

    assign idx         = bus_addr[4:2];
    assign key         = bus_wdata[15:0];
    assign addr_unused = ^{bus_addr[1:0], bus_wdata[DATA_W-1:16], bus_wdata[13:12]};

    always_comb begin
        d         = q;
        key_wr    = bus_wr && (idx == IDX_KEY);
        start_k   = key_wr && (key == KEY_START);
        refresh_k = key_wr && (key == KEY_REFRESH);
        if (key_wr) d.open = (key == KEY_OPEN);
        pre_wr    = bus_wr && (idx == IDX_PRE) && q.open;
        rld_wr    = bus_wr && (idx == IDX_RLD) && q.open;
        win_wr    = bus_wr && (idx == IDX_WIN) && q.open;
        ew_wr     = bus_wr && (idx == IDX_EWC);
        ack       = ew_wr && bus_wdata[EW_ACK_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.open <= 1'b0;
        else        q <= d;
    end

    kwdt_shadow #(.W(CODE_W), .RST_VAL('0), .BUSY_CYC(BUSY_CYC)) u_pre (
        .clk(clk), .rst_n(rst_n), .wr_i(pre_wr), .data_i(bus_wdata[CODE_W-1:0]),
        .pend_o(pre_pend), .act_o(pre_act), .busy_o(pre_busy));

    kwdt_shadow #(.W(CNT_W), .RST_VAL('1), .BUSY_CYC(BUSY_CYC)) u_rld (
        .clk(clk), .rst_n(rst_n), .wr_i(rld_wr), .data_i(bus_wdata[CNT_W-1:0]),
        .pend_o(rld_pend), .act_o(rld_act), .busy_o(rld_busy));

    kwdt_shadow #(.W(CNT_W), .RST_VAL('1), .BUSY_CYC(BUSY_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .wr_i(win_wr), .data_i(bus_wdata[CNT_W-1:0]),
        .pend_o(win_pend), .act_o(win_act), .busy_o(win_busy));

    kwdt_shadow #(.W(EW_W), .RST_VAL('0), .BUSY_CYC(BUSY_CYC)) u_ew (
        .clk(clk), .rst_n(rst_n), .wr_i(ew_wr),
        .data_i({bus_wdata[EW_EN_BIT], bus_wdata[CNT_W-1:0]}),
        .pend_o(ew_pend), .act_o(ew_act), .busy_o(ew_busy));

    kwdt_prescaler #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_ps (
        .clk(clk), .rst_n(rst_n), .run_i(running), .clr_i(load),
        .code_i(pre_act), .tick_o(tick));

    kwdt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .start_i(start_k), .refresh_i(refresh_k),
        .tick_i(tick), .ack_i(ack), .ew_en_i(ew_act[CNT_W]),
        .reload_i(rld_act), .win_i(win_act), .thr_i(ew_act[CNT_W-1:0]),
        .running_o(running), .load_o(load), .rst_req_o(wdg_reset_req),
        .flag_o(early_irq));

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_PRE:  bus_rdata[CODE_W-1:0] = pre_pend;
            IDX_RLD:  bus_rdata[CNT_W-1:0]  = rld_pend;
            IDX_WIN:  bus_rdata[CNT_W-1:0]  = win_pend;
            IDX_STAT: begin
                bus_rdata[0]           = pre_busy;
                bus_rdata[1]           = rld_busy;
                bus_rdata[2]           = win_busy;
                bus_rdata[3]           = ew_busy;
                bus_rdata[ST_FLAG_BIT] = early_irq;
            end
            IDX_EWC:  begin
                bus_rdata[CNT_W-1:0] = ew_pend[CNT_W-1:0];
                bus_rdata[EW_EN_BIT] = ew_pend[CNT_W];
            end
            default:  bus_rdata = '0;
        endcase
    end

    // R2: a write to a closed configuration word changes nothing
    a_r2_closed_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_RLD && !q.open) |=> $stable(rld_pend));

endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdg_reset_req, early_irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    kwdt_top dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdg_reset_req(wdg_reset_req), .early_irq(early_irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic cfg(input logic [31:0] pr, input logic [31:0] rl, input logic [31:0] wn);
        wr(5'h00, 32'h5555); wr(5'h04, pr); wr(5'h08, rl); wr(5'h10, wn);
        repeat (4) @(negedge clk);
    endtask

    // cycles from the current negedge until reset request is seen (lim if never)
    task automatic wait_rst(input int lim, output int n);
        n = 0;
        while (n < lim) begin
            @(negedge clk); n++;
            if (wdg_reset_req) break;
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(5'h00, v); check("R1 key", v, 0);
        rd(5'h04, v); check("R1 prescaler", v, 0);
        rd(5'h08, v); check("R1 reload", v, 32'hFFF);
        rd(5'h10, v); check("R1 window", v, 32'hFFF);
        rd(5'h0C, v); check("R1 status", v, 0);
        rd(5'h14, v); check("R1 early word", v, 0);
        check("R1 outputs", {wdg_reset_req, early_irq}, 0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        do_reset();
        wr(5'h08, 32'h5);
        rd(5'h08, v); check("R2 closed write", v, 32'hFFF);
        wr(5'h00, 32'h5555); wr(5'h00, 32'h1234); wr(5'h04, 32'h1);
        rd(5'h04, v); check("R2 relock", v, 0);
        wr(5'h00, 32'h5555); wr(5'h04, 32'h2);
        rd(5'h04, v); check("R2 open write", v, 32'h2);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        do_reset();
        wr(5'h00, 32'h5555); wr(5'h08, 32'h5); wr(5'h08, 32'h9);
        rd(5'h0C, v); check("R3 busy set", v, 32'h2);
        @(negedge clk); rd(5'h0C, v); check("R3 busy cycle 3", v, 32'h2);
        @(negedge clk); rd(5'h0C, v); check("R3 busy cleared", v, 0);
        rd(5'h08, v); check("R3 busy write dropped", v, 32'h5);
    endtask

    task automatic t_expiry();
        int n;
        do_reset(); cfg(0, 5, 32'hFFF);
        wr(5'h00, 32'hCCCC);
        wait_rst(100, n); check("R5 first expiry", n, 24);
        @(negedge clk); check("R5 single pulse", wdg_reset_req, 0);
        wait_rst(100, n); check("R5 repeat expiry", n, 23);
    endtask

    task automatic t_prescale();
        int n;
        do_reset(); cfg(1, 2, 32'hFFF); wr(5'h00, 32'hCCCC);
        wait_rst(100, n); check("R4 code 1", n, 24);
        do_reset(); cfg(8, 0, 32'hFFF); wr(5'h00, 32'hCCCC);
        wait_rst(2000, n); check("R4 code 8", n, 1024);
        do_reset(); cfg(12, 0, 32'hFFF); wr(5'h00, 32'hCCCC);
        wait_rst(2000, n); check("R4 code above 8", n, 1024);
    endtask

    task automatic t_refresh();
        int n;
        do_reset(); cfg(0, 5, 32'hFFF);
        wr(5'h00, 32'hAAAA);
        wait_rst(40, n); check("R6 idle refresh ignored", n, 40);
        wr(5'h00, 32'hCCCC);
        repeat (10) @(negedge clk);
        wr(5'h00, 32'hAAAA);
        wait_rst(100, n); check("R6 refresh reloads", n, 24);
    endtask

    task automatic t_window();
        int n;
        do_reset(); cfg(0, 20, 10); wr(5'h00, 32'hCCCC);
        repeat (3) @(negedge clk);
        wr(5'h00, 32'hAAAA);
        check("R7 violation pulse", wdg_reset_req, 1);
        wait_rst(200, n); check("R7 counter not reloaded", n, 80);
        do_reset(); cfg(0, 20, 10); wr(5'h00, 32'hCCCC);
        repeat (59) @(negedge clk);
        check("R7 no pulse before window", wdg_reset_req, 0);
        wr(5'h00, 32'hAAAA);
        check("R7 in-window refresh accepted", wdg_reset_req, 0);
        wait_rst(200, n); check("R7 in-window reload", n, 84);
    endtask

    task automatic t_early();
        int n;
        logic [31:0] v;
        do_reset(); cfg(0, 20, 32'hFFF);
        wr(5'h14, 32'h800A); repeat (4) @(negedge clk);
        wr(5'h00, 32'hCCCC);
        n = 0;
        while (n < 100 && !early_irq) begin @(negedge clk); n++; end
        check("R8 flag timing", n, 45);
        rd(5'h0C, v); check("R8 status flag", v[14], 1);
        wr(5'h14, 32'h800A);
        check("R9 write without ack keeps flag", early_irq, 1);
        wr(5'h14, 32'hC00A);
        check("R9 ack clears", early_irq, 0);
        repeat (3) @(negedge clk);
        check("R9 stays clear", early_irq, 0);
        rd(5'h14, v); check("R9 ack reads 0", v, 32'h800A);
        do_reset(); cfg(0, 20, 32'hFFF);
        wr(5'h14, 32'h000A); repeat (4) @(negedge clk);
        wr(5'h00, 32'hCCCC);
        n = 0;
        while (n < 90) begin @(negedge clk); n++; if (early_irq) break; end
        check("R8 disabled never sets", n, 90);
    endtask

    task automatic t_ew_busy();
        logic [31:0] v;
        do_reset();
        wr(5'h14, 32'h8003); wr(5'h14, 32'h0007);
        rd(5'h0C, v); check("R10 busy set", v, 32'h8);
        @(negedge clk); @(negedge clk); rd(5'h0C, v); check("R10 busy cleared", v, 0);
        rd(5'h14, v); check("R10 busy write dropped", v, 32'h8003);
    endtask

    task automatic t_nostop();
        int n;
        do_reset(); cfg(0, 5, 32'hFFF); wr(5'h00, 32'hCCCC);
        wr(5'h00, 32'h1234); wr(5'h00, 32'h0000);
        wait_rst(100, n); check("R11 keys do not stop", n, 22);
        do_reset();
        wait_rst(40, n); check("R11 reset returns idle", n, 40);
    endtask

    initial begin
        t_reset_state();
        t_lock();
        t_busy();
        t_expiry();
        t_prescale();
        t_refresh();
        t_window();
        t_early();
        t_ew_busy();
        t_nostop();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule